// File: doc/BRIEF.md
# Crossbar Output-Port Arbiter

This block decides which of six master-side requesters owns one output port of a multi-layer bus crossbar. Each output port has its own copy, so separate ports can carry transfers at the same time. Once a requester is granted, the grant is locked until the transfer in flight signals completion. Every other requester is stalled until then.

The winner is chosen by a policy selected at run time. The policies are fixed index order, programmable priority with a software-written rank per requester, and round-robin. A parking option is also available: when nobody is requesting, the grant rests on a chosen requester. That requester can then start at once without waiting an arbitration cycle.

A small state machine with three states controls the block. IDLE means no grant is held. PARK means a grant is held on the parking target but no transfer is locked. LOCK means a grant is held for a transfer in flight.

Arbitration happens in every cycle spent in IDLE or PARK, and in the LOCK cycle in which `xfer_done` is high. At that point the next state is chosen:
- LOCK, if any request is present;
- otherwise PARK, if parking is valid;
- otherwise IDLE.

The new grant appears after the next clock edge.

Top module: `xbar_port_arbiter`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first arbitration, `gnt` is all zeros and `gnt_idx` is 0.
- R2: `gnt` is one-hot or all zeros. `gnt_idx` is the bit position (0..5) of the set `gnt` bit, or 0 when `gnt` is all zeros.
- R3: An arbitration cycle is any cycle with no locked transfer, or a cycle with `xfer_done` high. If any `req` bit is set in that cycle, the grant after the next rising edge goes to a requester that was requesting.
- R4: A locked grant does not change until a cycle with `xfer_done` high, whatever `req` does.
- R5: With `cfg_mode` equal to 2'b00 or 2'b11 (fixed order), the lowest-numbered requesting index wins.
- R6: With `cfg_mode` equal to 2'b01 (programmable), requester i takes its rank from `cfg_prio[3i+2:3i]`. The larger value wins, and among equal values the lower index wins.
- R7: With `cfg_mode` equal to 2'b10 (round-robin), the search starts one index above the most recent winner and wraps from 5 to 0. The most recent winner is tracked in every mode and starts at 5 after reset.
- R8: In an arbitration cycle with no requests, `park_en` high and `park_sel` below 6, the grant moves to `park_sel`. If the parked requester then requests, it keeps the grant with no gap. If another requester wins instead, the grant moves to that requester.
- R9: In an arbitration cycle with no requests and either `park_en` low or `park_sel` of 6 or more, `gnt` becomes all zeros.
- R10: Changes to `cfg_mode` and `cfg_prio` during a locked transfer have no effect until the next arbitration cycle, where they apply at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 6 | One request bit per requester |
| xfer_done | input | 1 | Completion of the granted transfer |
| cfg_mode | input | 2 | Policy: 00 fixed, 01 programmable, 10 round-robin, 11 fixed |
| cfg_prio | input | 18 | Six 3-bit ranks, requester i at bits [3i+2:3i] |
| park_en | input | 1 | Enables parking when idle |
| park_sel | input | 3 | Parking target index |
| gnt | output | 6 | One-hot grant |
| gnt_idx | output | 3 | Encoded index of the grant |

## Verification
The bound checker covers the following on every cycle:
- the one-hot shape of the grant and its match with `gnt_idx`;
- the hold of a locked grant;
- that an arbitration always grants a current requester;
- the lowest-index rule in fixed mode;
- the move to the parking target, or to no grant, when requests are absent.

Some behaviours depend on history or on configuration applied over several transfers, and only the bench scenarios can show them:
- the round-robin rotation and its wrap;
- programmable ranking with ties;
- configuration writes deferred across a locked transfer;
- a parked requester starting with no gap.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;

    typedef enum logic [1:0] {
        POL_FIXED     = 2'b00,
        POL_PROG      = 2'b01,
        POL_RR        = 2'b10,
        POL_FIXED_ALT = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PARK = 2'b01,
        ST_LOCK = 2'b10
    } arb_state_e;

endpackage

// File: rtl/xbar_arb_fixed_pick.sv
module xbar_arb_fixed_pick #(
    parameter int NREQ  = 6,
    parameter int IDX_W = 3
) (
    input  logic [NREQ-1:0]  req,
    output logic [IDX_W-1:0] win
);
    always_comb begin
        logic found;
        found = 1'b0;
        win   = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (req[i] && !found) begin
                found = 1'b1;
                win   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/xbar_arb_prio_pick.sv
module xbar_arb_prio_pick #(
    parameter int NREQ   = 6,
    parameter int IDX_W  = 3,
    parameter int PRIO_W = 3
) (
    input  logic [NREQ-1:0]        req,
    input  logic [NREQ*PRIO_W-1:0] prio,
    output logic [IDX_W-1:0]       win
);
    always_comb begin
        logic              found;
        logic [PRIO_W-1:0] best;
        found = 1'b0;
        best  = '0;
        win   = '0;
        // strict compare keeps the lower index on equal ranks
        for (int i = 0; i < NREQ; i++) begin
            if (req[i] && (!found || (prio[i*PRIO_W +: PRIO_W] > best))) begin
                found = 1'b1;
                best  = prio[i*PRIO_W +: PRIO_W];
                win   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/xbar_arb_rr_pick.sv
module xbar_arb_rr_pick #(
    parameter int NREQ  = 6,
    parameter int IDX_W = 3
) (
    input  logic [NREQ-1:0]  req,
    input  logic [IDX_W-1:0] last,
    output logic [IDX_W-1:0] win
);
    always_comb begin
        logic found;
        int   cand;
        found = 1'b0;
        win   = '0;
        cand  = 0;
        for (int k = 1; k <= NREQ; k++) begin
            cand = int'(last) + k;
            if (cand >= NREQ) cand = cand - NREQ;
            if (!found && req[cand[IDX_W-1:0]]) begin
                found = 1'b1;
                win   = cand[IDX_W-1:0];
            end
        end
    end
endmodule

// File: rtl/xbar_port_arbiter.sv
module xbar_port_arbiter
    import xbar_arb_pkg::*;
#(
    parameter int NREQ   = 6,
    parameter int PRIO_W = 3,
    localparam int IDX_W = $clog2(NREQ)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREQ-1:0]        req,
    input  logic                   xfer_done,
    input  logic [1:0]             cfg_mode,
    input  logic [NREQ*PRIO_W-1:0] cfg_prio,
    input  logic                   park_en,
    input  logic [IDX_W-1:0]       park_sel,
    output logic [NREQ-1:0]        gnt,
    output logic [IDX_W-1:0]       gnt_idx
);
    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] owner_q, owner_d;
    logic [IDX_W-1:0] last_q,  last_d;
    logic [IDX_W-1:0] win_fixed, win_prio, win_rr, pick;
    logic             lock_active, arb_point, park_ok;

    xbar_arb_fixed_pick #(.NREQ(NREQ), .IDX_W(IDX_W)) u_fixed (
        .req (req),
        .win (win_fixed)
    );

    xbar_arb_prio_pick #(.NREQ(NREQ), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_prio (
        .req  (req),
        .prio (cfg_prio),
        .win  (win_prio)
    );

    xbar_arb_rr_pick #(.NREQ(NREQ), .IDX_W(IDX_W)) u_rr (
        .req  (req),
        .last (last_q),
        .win  (win_rr)
    );

    assign lock_active = (state_q == ST_LOCK);
    assign arb_point   = !lock_active || xfer_done;
    assign park_ok     = park_en && (int'(park_sel) < NREQ);

    always_comb begin
        unique case (policy_e'(cfg_mode))
            POL_PROG: pick = win_prio;
            POL_RR:   pick = win_rr;
            default:  pick = win_fixed;
        endcase
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        last_d  = last_q;
        unique case (state_q)
            ST_IDLE, ST_PARK, ST_LOCK: begin
                if (arb_point) begin
                    if (|req) begin
                        state_d = ST_LOCK;
                        owner_d = pick;
                        last_d  = pick;
                    end else if (park_ok) begin
                        state_d = ST_PARK;
                        owner_d = park_sel;
                    end else begin
                        state_d = ST_IDLE;
                        owner_d = '0;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                owner_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            last_q  <= IDX_W'(NREQ - 1);
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            last_q  <= last_d;
        end
    end

    // outputs from registered state only
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        if (state_q != ST_IDLE) begin
            gnt[owner_q] = 1'b1;
            gnt_idx      = owner_q;
        end
    end
endmodule

// File: rtl/xbar_port_arbiter_chk.sv
module xbar_port_arbiter_chk #(
    parameter int NREQ  = 6,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NREQ-1:0]  req,
    input logic             xfer_done,
    input logic [1:0]       cfg_mode,
    input logic             park_en,
    input logic [IDX_W-1:0] park_sel,
    input logic [NREQ-1:0]  gnt,
    input logic [IDX_W-1:0] gnt_idx,
    input logic             lock_active
);
    logic arb_now, fixed_mode, park_valid;
    assign arb_now    = !lock_active || xfer_done;
    assign fixed_mode = (cfg_mode == 2'b00) || (cfg_mode == 2'b11);
    assign park_valid = park_en && (int'(park_sel) < NREQ);

    p_gnt_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_idx_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |-> gnt[gnt_idx]);

    p_idx_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0) |-> (gnt_idx == '0));

    p_grant_to_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_now && (req != '0)) |=> ((gnt & $past(req)) != '0));

    p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_active && !xfer_done) |=> $stable(gnt));

    p_fixed_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_now && (req != '0) && fixed_mode)
        |=> (gnt == ($past(req) & (~$past(req) + NREQ'(1)))));

    p_park_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_now && (req == '0) && park_valid)
        |=> (gnt == (NREQ'(1) << $past(park_sel))));

    p_no_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_now && (req == '0) && !park_valid) |=> (gnt == '0));
endmodule

bind xbar_port_arbiter xbar_port_arbiter_chk #(.NREQ(NREQ), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .xfer_done   (xfer_done),
    .cfg_mode    (cfg_mode),
    .park_en     (park_en),
    .park_sel    (park_sel),
    .gnt         (gnt),
    .gnt_idx     (gnt_idx),
    .lock_active (lock_active)
);

// File: tb/test_xbar_port_arbiter.sv
module test_xbar_port_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  req = '0;
    logic        xfer_done = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [17:0] cfg_prio = '0;
    logic        park_en = 1'b0;
    logic [2:0]  park_sel = '0;
    logic [5:0]  gnt;
    logic [2:0]  gnt_idx;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    typedef struct {
        logic [5:0] g;
        string      tag;
    } exp_t;
    exp_t sb[$];

    xbar_port_arbiter i_xbar_port_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .xfer_done (xfer_done),
        .cfg_mode  (cfg_mode),
        .cfg_prio  (cfg_prio),
        .park_en   (park_en),
        .park_sel  (park_sel),
        .gnt       (gnt),
        .gnt_idx   (gnt_idx)
    );

    always #10 clk = ~clk;

    function automatic logic [2:0] idx_of(input logic [5:0] g);
        idx_of = '0;
        for (int i = 0; i < 6; i++) if (g[i]) idx_of = 3'(i);
    endfunction

    task automatic check(input string tag, input logic [5:0] got_g,
                         input logic [2:0] got_i, input logic [5:0] exp_g);
        checks++;
        if (got_g !== exp_g) begin
            fails++;
            $display("FAIL %s gnt actual=%b expected=%b", tag, got_g, exp_g);
        end
        checks++;
        if (got_i !== idx_of(exp_g)) begin
            fails++;
            $display("FAIL R2 (%s) gnt_idx actual=%0d expected=%0d", tag, got_i, idx_of(exp_g));
        end
    endtask

    task automatic step(input logic [5:0] r, input logic d,
                        input logic [5:0] exp_g, input string tag);
        @(negedge clk);
        req       = r;
        xfer_done = d;
        @(posedge clk);
        sb.push_back('{exp_g, tag});
        #1;
    endtask

    // monitor: pops the expected grant for each edge
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            check(it.tag, gnt, gnt_idx, it.g);
        end
    end

    task automatic summary;
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", gnt, gnt_idx, 6'b000000);
        rst_n = 1'b1;
        @(posedge clk); #1;

        step(6'b000000, 1'b0, 6'b000000, "R9 no request, parking off");
        step(6'b101000, 1'b0, 6'b001000, "R3 R5 fixed lowest index");
        step(6'b101001, 1'b0, 6'b001000, "R4 lock holds new request");
        cfg_mode = 2'b01;
        cfg_prio = {3'd7, 3'd0, 3'd0, 3'd0, 3'd2, 3'd2};
        step(6'b101001, 1'b0, 6'b001000, "R10 config change during lock");
        step(6'b101001, 1'b1, 6'b100000, "R6 R10 highest rank wins");
        step(6'b000011, 1'b1, 6'b000001, "R6 tie to lower index");
        cfg_mode = 2'b10;
        step(6'b111111, 1'b1, 6'b000010, "R7 round-robin after 0");
        step(6'b111111, 1'b1, 6'b000100, "R7 round-robin next");
        step(6'b100001, 1'b1, 6'b100000, "R7 skip to 5");
        step(6'b100001, 1'b1, 6'b000001, "R7 wrap 5 to 0");
        park_en  = 1'b1;
        park_sel = 3'd4;
        step(6'b000000, 1'b1, 6'b010000, "R8 park on 4");
        step(6'b000000, 1'b0, 6'b010000, "R8 stay parked");
        step(6'b010000, 1'b0, 6'b010000, "R8 parked requester no gap");
        step(6'b000001, 1'b0, 6'b010000, "R4 lock after park");
        step(6'b000010, 1'b1, 6'b000010, "R7 search from 5 wraps to 1");
        park_sel = 3'd2;
        step(6'b000000, 1'b1, 6'b000100, "R8 park on 2");
        step(6'b000001, 1'b0, 6'b000001, "R8 other requester takes parked port");
        park_sel = 3'd7;
        step(6'b000000, 1'b1, 6'b000000, "R9 invalid park target");
        park_en  = 1'b0;
        park_sel = 3'd3;
        step(6'b000000, 1'b0, 6'b000000, "R9 parking disabled");
        cfg_mode = 2'b11;
        step(6'b110000, 1'b0, 6'b010000, "R5 mode 11 fixed");
        step(6'b110000, 1'b1, 6'b010000, "R5 mode 11 regrant lowest");

        repeat (3) @(posedge clk);
        #5;
        summary();
    end
endmodule